// File: doc/BRIEF.md
# Wavetable Tone Voice with Direct Sample Mode

This block is a single voice of a programmable sound generator. Software fills a 32-slot table of 5-bit amplitudes that describe one period of an arbitrary waveform. A 12-bit divider sets how fast a phase index walks through that table. Each selected amplitude is multiplied by a separate 4-bit gain for the left and the right output. All configuration arrives through a byte-wide write port with a 3-bit register select.

Two alternative sample sources bypass the table. In direct mode, a byte written to the wave-data register becomes the channel sample straight away, so the host can stream PCM. In noise mode, a 15-bit linear feedback shift register, stepped at the divider rate, toggles the sample between its minimum and maximum codes. Mixing several voices, coupling between voices and digital-to-analogue conversion belong to the surrounding design.

Top module: `wave_voice`

## Requirements
- R1: After reset both outputs read 0, the divider, gains and control byte are 0, and the table write pointer points at slot 0.
- R2: Register select 4 (wave data) with direct mode off stores wr_data[4:0] at the write pointer and advances the pointer modulo 32. Writing the control register (select 2) with bit 7 clear returns the pointer to slot 0. A control write with bit 7 set leaves the pointer alone.
- R3: The divider F is {select 1 bits [3:0], select 0 bits [7:0]}, and bits [7:4] of select 1 are ignored. While running, the phase index holds each value for exactly F+1 clock cycles.
- R4: Setting control bit 7 (run) starts playback at slot 0. The output shows slot p from 2 cycles after the p-th phase step, and slots follow in order 0..31 and then wrap to 0.
- R5: Select 3 holds the left gain in [7:4] and the right gain in [3:0]. Each 9-bit output equals the current 5-bit sample times that side's gain.
- R6: While run is clear, both outputs are 0 from the cycle after the control write.
- R7: With control bit 6 (direct) set, a wave-data write neither changes the table nor moves the pointer. Its value, scaled by the gains, appears on the outputs one cycle after the write while run is set.
- R8: With control bit 5 (noise) set and direct clear, the sample is 31 when LFSR bit 14 is 1 and 0 otherwise. The LFSR holds seed 1 while stopped. On each phase step it shifts left, and the new bit 0 is bit 14 XOR bit 13. Its effect on the output shows from 1 cycle after the step.
- R9: A table slot rewritten during playback is read with its new value the next time the phase index reaches it.
- R10: Writes to register selects 5, 6 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 8 | Register write data |
| left_out | output | 9 | Left scaled sample, registered |
| right_out | output | 9 | Right scaled sample, registered |

## Verification
The bench builds the voice with its default parameters: 32 table slots, 5-bit samples, a 12-bit divider, 4-bit gains and a 15-bit noise register. At these sizes every gain value on each side can be crossed with every direct sample code, and a full table period can be replayed at several divider settings. The checks sample both the first and the last cycle of each phase window, so a period error of one cycle is visible. The noise sequence stays short enough to be compared bit for bit over sixty steps against an arithmetic model. The table can also be overfilled by one write to show the pointer wrapping.

// File: rtl/wv_pkg.sv
`timescale 1ns/1ps
package wv_pkg;
  // register select codes of the write port
  typedef enum logic [2:0] {
    A_FLO = 3'd0,
    A_FHI = 3'd1,
    A_CTL = 3'd2,
    A_VOL = 3'd3,
    A_WAV = 3'd4
  } reg_sel_e;

  // control byte, stored from the three top bits of the write data
  typedef struct packed {
    logic run;
    logic direct;
    logic noise;
  } ctl_t;
endpackage

// File: rtl/wv_regs.sv
`timescale 1ns/1ps
module wv_regs
  import wv_pkg::*;
#(
  parameter int REG_W  = 8,
  parameter int FREQ_W = 12,
  parameter int VOL_W  = 4,
  parameter int SAMP_W = 5,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  output logic [FREQ_W-1:0] freq,
  output logic [VOL_W-1:0]  vol_l,
  output logic [VOL_W-1:0]  vol_r,
  output ctl_t              ctl,
  output logic              tbl_we,
  output logic [IDX_W-1:0]  tbl_waddr,
  output logic [SAMP_W-1:0] tbl_wdata,
  output logic [SAMP_W-1:0] dda
);
  localparam int HI_W = FREQ_W - REG_W;

  logic [REG_W-1:0]  lo_q;
  logic [HI_W-1:0]   hi_q;
  logic [IDX_W-1:0]  ptr_q;
  logic [SAMP_W-1:0] dda_q;
  logic hit_lo, hit_hi, hit_ctl, hit_vol, hit_wav;

  always_comb begin
    hit_lo  = wr_en && (wr_addr == A_FLO);
    hit_hi  = wr_en && (wr_addr == A_FHI);
    hit_ctl = wr_en && (wr_addr == A_CTL);
    hit_vol = wr_en && (wr_addr == A_VOL);
    hit_wav = wr_en && (wr_addr == A_WAV);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q  <= '0;
      hi_q  <= '0;
      ctl   <= '0;
      vol_l <= '0;
      vol_r <= '0;
    end else begin
      if (hit_lo)  lo_q <= wr_data;
      if (hit_hi)  hi_q <= wr_data[HI_W-1:0];
      if (hit_ctl) ctl  <= wr_data[REG_W-1 -: 3];
      if (hit_vol) begin
        vol_l <= wr_data[2*VOL_W-1:VOL_W];
        vol_r <= wr_data[VOL_W-1:0];
      end
    end
  end

  // table writes are diverted while the direct path is selected
  assign tbl_we    = hit_wav && !ctl.direct;
  assign tbl_waddr = ptr_q;
  assign tbl_wdata = wr_data[SAMP_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (hit_ctl && !wr_data[REG_W-1]) begin
      ptr_q <= '0;
    end else if (tbl_we) begin
      ptr_q <= ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dda_q <= '0;
    end else if (hit_wav && ctl.direct) begin
      dda_q <= wr_data[SAMP_W-1:0];
    end
  end

  assign freq = {hi_q, lo_q};
  assign dda  = dda_q;
endmodule

// File: rtl/wv_table.sv
`timescale 1ns/1ps
module wv_table #(
  parameter int DEPTH  = 32,
  parameter int SAMP_W = 5,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [SAMP_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [SAMP_W-1:0] rdata
);
  logic [SAMP_W-1:0] mem [DEPTH];

  // simple dual-port RAM, registered read, no reset on the array
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/wv_phase.sv
`timescale 1ns/1ps
module wv_phase #(
  parameter int FREQ_W   = 12,
  parameter int IDX_W    = 5,
  parameter int LFSR_W   = 15,
  parameter bit NOISE_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [FREQ_W-1:0] freq,
  output logic [FREQ_W-1:0] cnt,
  output logic [IDX_W-1:0]  phase,
  output logic [LFSR_W-1:0] lfsr
);
  localparam logic [LFSR_W-1:0] SEED = LFSR_W'(1);

  logic tick;
  assign tick = run && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      phase <= '0;
    end else if (!run) begin
      cnt   <= freq;
      phase <= '0;
    end else if (tick) begin
      cnt   <= freq;
      phase <= phase + 1'b1;
    end else begin
      cnt   <= cnt - 1'b1;
    end
  end

  generate
    if (NOISE_EN) begin : g_noise
      logic [LFSR_W-1:0] sr_q;
      always_ff @(posedge clk) begin
        if (rst || !run) begin
          sr_q <= SEED;
        end else if (tick) begin
          sr_q <= {sr_q[LFSR_W-2:0], sr_q[LFSR_W-1] ^ sr_q[LFSR_W-2]};
        end
      end
      assign lfsr = sr_q;
    end else begin : g_quiet
      assign lfsr = SEED;
    end
  endgenerate
endmodule

// File: rtl/wv_scale.sv
`timescale 1ns/1ps
module wv_scale #(
  parameter int SAMP_W = 5,
  parameter int VOL_W  = 4,
  parameter int OUT_W  = SAMP_W + VOL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              direct,
  input  logic              noise_on,
  input  logic              noise_bit,
  input  logic [SAMP_W-1:0] tbl_q,
  input  logic [SAMP_W-1:0] dda,
  input  logic [VOL_W-1:0]  vol_l,
  input  logic [VOL_W-1:0]  vol_r,
  output logic [OUT_W-1:0]  left_out,
  output logic [OUT_W-1:0]  right_out
);
  logic [SAMP_W-1:0] samp;
  logic [VOL_W-1:0]  gain [2];
  logic [OUT_W-1:0]  prod_q [2];

  // source priority: stopped, direct, noise, table
  always_comb begin
    if (!run)          samp = '0;
    else if (direct)   samp = dda;
    else if (noise_on) samp = noise_bit ? '1 : '0;
    else               samp = tbl_q;
  end

  assign gain[0] = vol_l;
  assign gain[1] = vol_r;

  always_ff @(posedge clk) begin
    for (int s = 0; s < 2; s++) begin
      if (rst) prod_q[s] <= '0;
      else     prod_q[s] <= OUT_W'(samp) * OUT_W'(gain[s]);
    end
  end

  assign left_out  = prod_q[0];
  assign right_out = prod_q[1];
endmodule

// File: rtl/wave_voice.sv
`timescale 1ns/1ps
module wave_voice
  import wv_pkg::*;
#(
  parameter int DEPTH    = 32,
  parameter int SAMP_W   = 5,
  parameter int FREQ_W   = 12,
  parameter int VOL_W    = 4,
  parameter int LFSR_W   = 15,
  parameter bit NOISE_EN = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [2:0]                wr_addr,
  input  logic [7:0]                wr_data,
  output logic [SAMP_W+VOL_W-1:0]   left_out,
  output logic [SAMP_W+VOL_W-1:0]   right_out
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int OUT_W = SAMP_W + VOL_W;
  localparam int REG_W = 8;

  logic [FREQ_W-1:0] freq;
  logic [VOL_W-1:0]  vol_l, vol_r;
  ctl_t              ctl;
  logic              tbl_we;
  logic [IDX_W-1:0]  tbl_waddr;
  logic [SAMP_W-1:0] tbl_wdata;
  logic [SAMP_W-1:0] dda;
  logic [FREQ_W-1:0] cnt;
  logic [IDX_W-1:0]  phase;
  logic [LFSR_W-1:0] lfsr;
  logic [SAMP_W-1:0] tbl_q;
  logic              noise_on;

  wv_regs #(.REG_W(REG_W), .FREQ_W(FREQ_W), .VOL_W(VOL_W),
            .SAMP_W(SAMP_W), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .freq(freq), .vol_l(vol_l), .vol_r(vol_r), .ctl(ctl),
    .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata), .dda(dda)
  );

  wv_table #(.DEPTH(DEPTH), .SAMP_W(SAMP_W), .IDX_W(IDX_W)) u_table (
    .clk(clk), .we(tbl_we), .waddr(tbl_waddr), .wdata(tbl_wdata),
    .raddr(phase), .rdata(tbl_q)
  );

  wv_phase #(.FREQ_W(FREQ_W), .IDX_W(IDX_W), .LFSR_W(LFSR_W),
             .NOISE_EN(NOISE_EN)) u_phase (
    .clk(clk), .rst(rst), .run(ctl.run), .freq(freq),
    .cnt(cnt), .phase(phase), .lfsr(lfsr)
  );

  assign noise_on = ctl.noise && NOISE_EN;

  wv_scale #(.SAMP_W(SAMP_W), .VOL_W(VOL_W), .OUT_W(OUT_W)) u_scale (
    .clk(clk), .rst(rst), .run(ctl.run), .direct(ctl.direct),
    .noise_on(noise_on), .noise_bit(lfsr[LFSR_W-1]),
    .tbl_q(tbl_q), .dda(dda), .vol_l(vol_l), .vol_r(vol_r),
    .left_out(left_out), .right_out(right_out)
  );
endmodule

// File: rtl/wave_voice_chk.sv
`timescale 1ns/1ps
module wave_voice_chk #(
  parameter int SAMP_W = 5,
  parameter int VOL_W  = 4,
  parameter int FREQ_W = 12,
  parameter int IDX_W  = 5,
  parameter int LFSR_W = 15
) (
  input logic              clk,
  input logic              rst,
  input logic              run,
  input logic              direct,
  input logic [FREQ_W-1:0] cnt,
  input logic [IDX_W-1:0]  phase,
  input logic              tbl_we,
  input logic [IDX_W-1:0]  tbl_waddr,
  input logic [LFSR_W-1:0] lfsr,
  input logic [SAMP_W-1:0] dda,
  input logic [VOL_W-1:0]  vol_l,
  input logic [SAMP_W+VOL_W-1:0] left_out,
  input logic [SAMP_W+VOL_W-1:0] right_out
);
  localparam int OUT_W = SAMP_W + VOL_W;

  // R6
  stopped_silent_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!run) |-> (left_out == '0 && right_out == '0));

  // R3
  phase_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run && cnt == '0) |=> (phase == $past(phase) + 1'b1));

  // R3
  phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run && cnt != '0) |=> $stable(phase));

  // R2
  ptr_adv_chk: assert property (@(posedge clk) disable iff (rst)
    tbl_we |=> (tbl_waddr == $past(tbl_waddr) + 1'b1));

  // R7
  direct_out_chk: assert property (@(posedge clk) disable iff (rst)
    (run && direct) |=> (left_out == OUT_W'($past(dda)) * OUT_W'($past(vol_l))));

  // R5
  left_mute_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(vol_l) == '0) |-> (left_out == '0));

  // R8
  lfsr_live_chk: assert property (@(posedge clk) disable iff (rst)
    lfsr != '0);
endmodule

bind wave_voice wave_voice_chk #(
  .SAMP_W(SAMP_W), .VOL_W(VOL_W), .FREQ_W(FREQ_W), .IDX_W(IDX_W), .LFSR_W(LFSR_W)
) u_chk (
  .clk(clk), .rst(rst), .run(ctl.run), .direct(ctl.direct), .cnt(cnt),
  .phase(phase), .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .lfsr(lfsr),
  .dda(dda), .vol_l(vol_l), .left_out(left_out), .right_out(right_out)
);

// File: tb/tb_wave_voice.sv
`timescale 1ns/1ps
module tb_wave_voice;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [8:0] left_out, right_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int tm [32];   // model of table contents
  int ptr_m = 0; // model of write pointer
  bit dir_m = 1'b0;

  always #2 clk = ~clk;

  wave_voice dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .left_out(left_out), .right_out(right_out)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ctl(input int d);
    wr(2, d);
    dir_m = d[6];
    if (!d[7]) ptr_m = 0;
  endtask

  task automatic wv(input int v);
    wr(4, v);
    if (!dir_m) begin
      tm[ptr_m] = v % 32;
      ptr_m = (ptr_m + 1) % 32;
    end
  endtask

  task automatic setf(input int f);
    wr(0, f & 255);
    wr(1, f >> 8);
  endtask

  task automatic goto(inout int pos, input int t);
    while (pos < t) begin
      @(negedge clk);
      pos++;
    end
  endtask

  // start from slot 0, check each step at both ends of its window, then stop
  task automatic play(input int f, input int nsteps, input int lv, input int rv, input string tag);
    int pos;
    int t;
    ctl(8'h80);
    pos = 0;
    for (int p = 0; p < nsteps; p++) begin
      t = p * (f + 1) + 2;
      goto(pos, t);
      chk(tag, left_out, tm[p % 32] * lv);
      chk(tag, right_out, tm[p % 32] * rv);
      if (f >= 1) begin
        goto(pos, t + f);
        chk(tag, left_out, tm[p % 32] * lv);
        chk(tag, right_out, tm[p % 32] * rv);
      end
    end
    ctl(8'h00);
    @(negedge clk);
    chk("R6 stop", left_out, 0);
    chk("R6 stop", right_out, 0);
  endtask

  initial begin
    int pos;
    int s;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 left", left_out, 0);
    chk("R1 right", right_out, 0);

    // R1 pointer at slot 0 without any control write; R4 order at F=0
    for (int i = 0; i < 32; i++) wv((i * 13 + 7) % 32);
    wr(3, 8'hF7);
    setf(0);
    play(0, 40, 15, 7, "R4 order F0");

    // R10: writes to unused selects change nothing
    wr(5, 8'hFF); wr(6, 8'hFF); wr(7, 8'hFF);
    play(0, 34, 15, 7, "R10 unused");

    // R3/R5 at F=1 with uneven gains
    wr(3, 8'h39);
    setf(1);
    play(1, 34, 3, 9, "R3 R5 F1");

    // R3: upper nibble of high byte ignored, F = 0x103
    wr(0, 8'h03);
    wr(1, 8'hF1);
    play(259, 3, 3, 9, "R3 hi ignored");

    // R2: overfill by one, slot 0 takes the 33rd value
    ctl(8'h00);
    for (int i = 0; i < 33; i++) wv((i * 7 + 3) % 32);
    chk("R2 model", tm[0], (32 * 7 + 3) % 32);
    setf(2);
    wr(3, 8'hAF);
    play(2, 33, 10, 15, "R2 wrap");

    // R9: rewrite slot 0 during playback
    setf(40);
    ctl(8'h80);
    pos = 0;
    goto(pos, 43);
    chk("R9 step1", left_out, tm[1] * 10);
    wv(5'h1E);
    pos += 2;
    for (int p = 2; p < 34; p++) begin
      goto(pos, p * 41 + 2);
      chk("R9 rewrite", left_out, tm[p % 32] * 10);
      chk("R9 rewrite", right_out, tm[p % 32] * 15);
    end
    ctl(8'h00);

    // R7/R5: every gain against every direct sample
    ctl(8'hC0);
    for (int lv = 0; lv < 16; lv++) begin
      wr(3, (lv << 4) | (15 - lv));
      for (int sv = 0; sv < 32; sv++) begin
        wr(4, sv);
        @(negedge clk);
        chk("R7 R5 direct L", left_out, sv * lv);
        chk("R7 R5 direct R", right_out, sv * (15 - lv));
      end
    end
    // R10 in direct mode: output holds
    wr(5, 8'hFF); wr(6, 8'h00); wr(7, 8'hFF);
    @(negedge clk);
    chk("R10 direct hold", left_out, 31 * 15);
    chk("R10 direct hold", right_out, 0);
    // R7: table untouched and pointer not moved by direct writes
    ctl(8'h80);
    wv(5'h0A);
    ctl(8'h00);
    chk("R7 model", tm[0], 10);
    wr(3, 8'hF1);
    setf(1);
    play(1, 32, 15, 1, "R7 table kept");

    // R8: noise sequence
    setf(3);
    wr(3, 8'hFF);
    ctl(8'hA0);
    pos = 0;
    s = 1;
    for (int p = 0; p < 60; p++) begin
      if (p > 0) s = ((s << 1) & 16'h7FFF) | (((s >> 14) ^ (s >> 13)) & 1);
      goto(pos, p * 4 + 2);
      chk("R8 noise", left_out, ((s >> 14) & 1) ? 465 : 0);
      chk("R8 noise", right_out, ((s >> 14) & 1) ? 465 : 0);
    end
    ctl(8'h00);
    @(negedge clk);
    chk("R6 after noise", left_out, 0);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule